// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block sits between a simple register port and a raw 8-bit NAND flash device. Software sets the timing through one configuration word. That word holds a setup length, a strobe-low length and a hold length, along with a controller enable and a direct drive for the chip-enable pin. A write to the command register or the address register runs one latch cycle on the flash pins. Each write or read of the data register runs one data strobe. A status register gives the synchronized state of the ready/busy pin.

Every bus cycle has three phases. First comes setup, where the latch lines and the write data are driven. Next comes the low phase of the write or read strobe. Last comes hold, where everything stays stable. Each phase lasts its configured field value plus one clock.

The request side is a valid/ready handshake. The block lowers `req_ready` from the accepted command, address or data access until the last hold clock of that cycle is over, so a back-to-back access waits for the flash bus to go idle. Responses come out as a one-cycle `rsp_valid` pulse without back-pressure, and the requester must take the pulse when it appears. A data read response appears only after its whole cycle has completed.

Top module: `nand_bus_seq`

## Requirements
- R1: After reset the following hold: the controller is disabled, `nand_ce_n` is 1, CLE and ALE are 0, nWE and nRE are 1, `nand_io_oe` is 0, `req_ready` is 1, and the configuration reads back as 0x0B77.
- R2: While the enable bit (bit 15 of the configuration word) is 0, command, address and data accesses are accepted but cause no pin activity. A data read in this state returns 0.
- R3: Each cycle has three phases in order. Setup lasts `cfg[9:8]`+1 clocks with both strobes high. The strobe is then low for `cfg[6:4]`+1 clocks. Hold follows for `cfg[2:0]`+1 clocks before the pins return to idle.
- R4: For the whole cycle, CLE is 1 on a command cycle and ALE is 1 on an address cycle. On data cycles both are 0. CLE and ALE are never 1 together.
- R5: A data read pulses nRE and samples `nand_io_in` on the clock where nRE rises. The sampled byte is returned on `rsp_data[7:0]` with the upper bits zero.
- R6: On write cycles `nand_io_oe` is 1 for all three phases and `nand_io_out` holds the written byte. On read cycles `nand_io_oe` is 0.
- R7: From the clock that accepts a command, address or data access until the cycle ends, `req_ready` is 0 and any strobe or latch line is active. nWE and nRE are never low together.
- R8: A data read answers with `rsp_valid` in the first idle clock after the hold phase. A configuration, status or unmapped read answers with `rsp_valid` in the clock after it is accepted.
- R9: Status bit 0 is the ready/busy pin after a two-flop synchronizer, where 1 means ready and 0 means busy. Status bits 15:1 read 0.
- R10: `nand_ce_n` follows configuration bit 11, where 1 deselects the chip. This holds whatever the state of the enable bit.
- R11: Register byte offsets are configuration 0x00, command 0x04, address 0x08, data 0x0C and status 0x10. Reads of any other offset return 0, and writes to any other offset change nothing. Configuration bits other than 15, 11, 9:8, 6:4 and 2:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted on this clock |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 5 | Register byte offset |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response pulse |
| rsp_data | output | 16 | Read response data |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Flash I/O data driven out |
| nand_io_oe | output | 1 | Flash I/O output enable |
| nand_io_in | input | 8 | Flash I/O data sampled in |
| nand_rb | input | 1 | Flash ready/busy, 1 means ready |

## Verification
The assertions check on every clock that the two strobes are never low together and that CLE and ALE never overlap. They also check that the written byte stays stable for a whole cycle, that the port stalls whenever the flash pins are active, that a disabled controller leaves the strobes idle, and that a completed data read produces a response. Only the bench scenarios can show that each phase lasts exactly its field value plus one. The bench sweeps all 256 timing settings for each of the four cycle kinds to show this. The scenarios also show that the right byte is captured at the rising edge of nRE, and that the reset word, chip enable, status synchronization and unmapped offsets behave as stated.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam int REG_W       = 16;
  localparam int FLASH_W     = 8;
  localparam int OFS_W       = 5;

  localparam int EN_BIT      = 15;
  localparam int CE_BIT      = 11;
  localparam int SETUP_LSB   = 8;
  localparam int SETUP_W     = 2;
  localparam int PULSE_LSB   = 4;
  localparam int PULSE_W     = 3;
  localparam int HOLD_LSB    = 0;
  localparam int HOLD_W      = 3;

  localparam logic [REG_W-1:0] SETUP_MASK = REG_W'(((1 << SETUP_W) - 1) << SETUP_LSB);
  localparam logic [REG_W-1:0] PULSE_MASK = REG_W'(((1 << PULSE_W) - 1) << PULSE_LSB);
  localparam logic [REG_W-1:0] HOLD_MASK  = REG_W'(((1 << HOLD_W) - 1) << HOLD_LSB);
  localparam logic [REG_W-1:0] CFG_WMASK  = REG_W'((1 << EN_BIT) | (1 << CE_BIT))
                                            | SETUP_MASK | PULSE_MASK | HOLD_MASK;
  localparam logic [REG_W-1:0] CFG_RESET  = REG_W'(1 << CE_BIT)
                                            | SETUP_MASK | PULSE_MASK | HOLD_MASK;

  // register slot = byte offset / 4
  localparam logic [OFS_W-3:0] SLOT_CFG  = 3'd0;
  localparam logic [OFS_W-3:0] SLOT_CMD  = 3'd1;
  localparam logic [OFS_W-3:0] SLOT_ADDR = 3'd2;
  localparam logic [OFS_W-3:0] SLOT_DATA = 3'd3;
  localparam logic [OFS_W-3:0] SLOT_STAT = 3'd4;

  typedef enum logic [1:0] {OP_CMD, OP_ADDR, OP_WR, OP_RD} op_e;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HOLD} phase_e;
endpackage

// File: rtl/nfc_sync2.sv
module nfc_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/nfc_phase_seq.sv
module nfc_phase_seq
  import nfc_pkg::*;
#(
  parameter int S_W  = SETUP_W,
  parameter int P_W  = PULSE_W,
  parameter int H_W  = HOLD_W,
  parameter int IO_W = FLASH_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  op_e             op,
  input  logic [IO_W-1:0] wbyte,
  input  logic [S_W-1:0]  setup_len,
  input  logic [P_W-1:0]  pulse_len,
  input  logic [H_W-1:0]  hold_len,
  output logic            busy,
  output logic            done,
  output logic [IO_W-1:0] rbyte,
  output logic            cle,
  output logic            ale,
  output logic            we_n,
  output logic            re_n,
  output logic [IO_W-1:0] io_out,
  output logic            io_oe,
  input  logic [IO_W-1:0] io_in
);
  localparam int SP_W  = (S_W > P_W) ? S_W : P_W;
  localparam int CNT_W = (SP_W > H_W) ? SP_W : H_W;

  phase_e            phase_q;
  op_e               op_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IO_W-1:0]   byte_q;
  logic              last;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      op_q    <= OP_CMD;
      cnt_q   <= '0;
      byte_q  <= '0;
      rbyte   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_SETUP;
          cnt_q   <= CNT_W'(setup_len);
          op_q    <= op;
          byte_q  <= wbyte;
        end
        PH_SETUP: if (last) begin
          phase_q <= PH_LOW;
          cnt_q   <= CNT_W'(pulse_len);
        end else cnt_q <= cnt_q - 1'b1;
        PH_LOW: if (last) begin
          phase_q <= PH_HOLD;
          cnt_q   <= CNT_W'(hold_len);
          if (op_q == OP_RD) rbyte <= io_in;   // nRE rising edge
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (last) phase_q <= PH_IDLE;
                 else      cnt_q   <= cnt_q - 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy   = (phase_q != PH_IDLE);
  assign done   = (phase_q == PH_HOLD) && last;
  assign cle    = busy && (op_q == OP_CMD);
  assign ale    = busy && (op_q == OP_ADDR);
  assign we_n   = !((phase_q == PH_LOW) && (op_q != OP_RD));
  assign re_n   = !((phase_q == PH_LOW) && (op_q == OP_RD));
  assign io_oe  = busy && (op_q != OP_RD);
  assign io_out = byte_q;

  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  a_r4_latches_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  a_r6_byte_held_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(io_out));
  a_r3_low_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(we_n) || $fell(re_n)) |-> ($past(phase_q) == PH_SETUP));
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
  import nfc_pkg::*;
#(
  parameter int RW  = REG_W,
  parameter int AW  = OFS_W,
  parameter int FW  = FLASH_W,
  parameter int SYN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [RW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [RW-1:0] rsp_data,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_ce_n,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic [FW-1:0] nand_io_out,
  output logic          nand_io_oe,
  input  logic [FW-1:0] nand_io_in,
  input  logic          nand_rb
);
  logic [RW-1:0]   cfg_q;
  logic            pend_q;
  logic            rb_sync;
  logic            seq_busy, seq_done, start;
  logic [FW-1:0]   seq_rbyte;
  logic [AW-3:0]   slot;
  logic            aligned, fire, is_bus, cfg_en;
  op_e             op;
  logic [RW-1:0]   rd_mux;

  assign slot      = req_addr[AW-1:2];
  assign aligned   = (req_addr[1:0] == 2'b00);
  assign req_ready = !seq_busy;
  assign fire      = req_valid && req_ready;
  assign cfg_en    = cfg_q[EN_BIT];

  always_comb begin
    is_bus = 1'b0;
    op     = OP_CMD;
    if (aligned) begin
      unique case (slot)
        SLOT_CMD:  begin is_bus = req_write; op = OP_CMD;  end
        SLOT_ADDR: begin is_bus = req_write; op = OP_ADDR; end
        SLOT_DATA: begin is_bus = 1'b1; op = req_write ? OP_WR : OP_RD; end
        default:   is_bus = 1'b0;
      endcase
    end
  end

  assign start = fire && is_bus && cfg_en;

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (slot == SLOT_CFG)  rd_mux = cfg_q;
      if (slot == SLOT_STAT) rd_mux = RW'(rb_sync);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= CFG_RESET;
      pend_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (fire && req_write && aligned && slot == SLOT_CFG)
        cfg_q <= req_wdata & CFG_WMASK;
      if (fire && !req_write) begin
        if (start) pend_q <= 1'b1;
        else begin
          rsp_valid <= 1'b1;
          rsp_data  <= rd_mux;
        end
      end
      if (pend_q && seq_done) begin
        pend_q    <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_data  <= RW'(seq_rbyte);
      end
    end
  end

  assign nand_ce_n = cfg_q[CE_BIT];

  nfc_sync2 #(.STAGES(SYN)) u_rb_sync (
    .clk(clk), .rst_n(rst_n), .d(nand_rb), .q(rb_sync)
  );

  nfc_phase_seq #(.S_W(SETUP_W), .P_W(PULSE_W), .H_W(HOLD_W), .IO_W(FW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .wbyte(req_wdata[FW-1:0]),
    .setup_len(cfg_q[SETUP_LSB +: SETUP_W]),
    .pulse_len(cfg_q[PULSE_LSB +: PULSE_W]),
    .hold_len(cfg_q[HOLD_LSB +: HOLD_W]),
    .busy(seq_busy), .done(seq_done), .rbyte(seq_rbyte),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
    .io_out(nand_io_out), .io_oe(nand_io_oe), .io_in(nand_io_in)
  );

  a_r7_port_stalls_while_active: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n || nand_cle || nand_ale) |-> !req_ready);
  a_r2_idle_pins_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale));
  a_r8_read_answered_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && seq_done) |=> rsp_valid);
  a_r5_read_rsp_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && seq_done) |=> (rsp_data[RW-1:FW] == '0));
endmodule

// File: tb/tb_nand_bus_seq.sv
module tb_nand_bus_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        nand_cle, nand_ale, nand_ce_n, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0]  nand_io_out, nand_io_in;
  logic        nand_rb = 1'b1;
  logic [7:0]  flash_byte = 8'h00;
  int          n_tests = 0;
  int          n_fail = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  // flash drives the bus only while nRE is low
  assign nand_io_in = nand_re_n ? 8'h5A : flash_byte;

  nand_bus_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_io_in(nand_io_in), .nand_rb(nand_rb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [15:0] d, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 64) begin lat++; @(negedge clk); end
    d = rsp_data;
  endtask

  // kind: 0 command, 1 address, 2 data write, 3 data read
  task automatic run_cycle(input int kind, input logic [7:0] b,
                           input int es, input int ep, input int eh);
    int s = 0, l = 0, h = 0, guard = 0;
    bit seen = 0, lat_ok = 1, dat_ok = 1;
    logic strobe, other;
    flash_byte = b;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = (kind != 3);
    req_addr  = (kind == 0) ? 5'h04 : (kind == 1) ? 5'h08 : 5'h0C;
    req_wdata = {8'h00, b};
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready && guard < 64) begin
      guard++;
      strobe = (kind == 3) ? nand_re_n : nand_we_n;
      other  = (kind == 3) ? nand_we_n : nand_re_n;
      if (!other) lat_ok = 0;
      if (!strobe) begin l++; seen = 1; end
      else if (!seen) s++;
      else h++;
      if (nand_cle !== (kind == 0)) lat_ok = 0;
      if (nand_ale !== (kind == 1)) lat_ok = 0;
      if (nand_io_oe !== (kind != 3)) dat_ok = 0;
      if (kind != 3 && nand_io_out !== b) dat_ok = 0;
      @(negedge clk);
    end
    chk(guard < 64, "R7 cycle ends and port reopens", guard, es + ep + eh);
    chk(s == es, "R3 setup phase length", s, es);
    chk(l == ep, "R3 strobe-low phase length", l, ep);
    chk(h == eh, "R3 hold phase length", h, eh);
    chk(lat_ok, "R4 latch lines per cycle kind", lat_ok, 1);
    chk(dat_ok, "R6 bus drive and byte", dat_ok, 1);
    if (kind == 3) begin
      chk(rsp_valid === 1'b1, "R8 read response in first idle clock", rsp_valid, 1);
      chk(rsp_data === {8'h00, b}, "R5 sampled byte", rsp_data, {8'h00, b});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int lat;
    bit quiet;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(nand_ce_n === 1'b1, "R1 chip deselected", nand_ce_n, 1);
    chk(!nand_cle && !nand_ale && nand_we_n && nand_re_n && !nand_io_oe,
        "R1 idle pins", {nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe}, 5'b00110);
    chk(req_ready === 1'b1, "R1 port ready", req_ready, 1);
    reg_read(5'h00, rd, lat);
    chk(rd == 16'h0B77, "R1 reset configuration", rd, 16'h0B77);
    chk(lat == 0, "R8 config read latency", lat, 0);

    // R2 disabled: no pin activity, data read returns 0
    reg_write(5'h04, 16'h00AA);
    quiet = 1;
    for (int i = 0; i < 30; i++) begin
      if (nand_cle || nand_ale || !nand_we_n || !nand_re_n || !req_ready) quiet = 0;
      @(negedge clk);
    end
    chk(quiet, "R2 command ignored when disabled", quiet, 1);
    flash_byte = 8'h3C;
    reg_read(5'h0C, rd, lat);
    chk(rd == 16'h0000 && lat == 0, "R2 data read returns zero when disabled", rd, 0);

    // R10 chip enable follows bit 11 regardless of enable
    reg_write(5'h00, 16'h0000);
    chk(nand_ce_n === 1'b0, "R10 chip enable low", nand_ce_n, 0);
    reg_write(5'h00, 16'h8800);
    chk(nand_ce_n === 1'b1, "R10 chip enable high", nand_ce_n, 1);

    // R11 masking and unmapped offsets
    reg_write(5'h00, 16'hFFFF);
    reg_read(5'h00, rd, lat);
    chk(rd == 16'h8B77, "R11 reserved config bits read 0", rd, 16'h8B77);
    reg_write(5'h14, 16'h0000);
    reg_write(5'h01, 16'h0000);
    reg_read(5'h00, rd, lat);
    chk(rd == 16'h8B77, "R11 unmapped write changes nothing", rd, 16'h8B77);
    reg_read(5'h14, rd, lat);
    chk(rd == 16'h0000 && lat == 0, "R11 unmapped read returns zero", rd, 0);

    // R9 status through synchronizer
    nand_rb = 1'b0;
    repeat (3) @(negedge clk);
    reg_read(5'h10, rd, lat);
    chk(rd == 16'h0000, "R9 status busy", rd, 0);
    nand_rb = 1'b1;
    repeat (3) @(negedge clk);
    reg_read(5'h10, rd, lat);
    chk(rd == 16'h0001 && lat == 0, "R9 status ready", rd, 1);

    // R3..R8 exhaustive timing sweep for every cycle kind
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 8; p++)
          for (int h = 0; h < 8; h++) begin
            reg_write(5'h00, 16'h8000 | 16'(s << 8) | 16'(p << 4) | 16'(h));
            run_cycle(k, 8'((s * 64 + p * 8 + h + k * 37) & 8'hFF), s + 1, p + 1, h + 1);
          end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule